// File: doc/BRIEF.md
# Multiplexed BCD Display Scanner with Blanking

This block drives an eight-digit multiplexed numeric display from a set of latched BCD decades. A slow scan clock, sampled in the core clock domain, steps the scanner one digit per falling edge. The walk starts at the most significant digit, ends at the least significant digit, and then starts over. For every digit time the scanner puts that digit's value on a shared 4-bit BCD bus. It also raises the matching one-hot strobe, which an external latch uses as its enable to demultiplex the bus.

A blank output suppresses leading zeros. Suppression is re-armed at the start of every pass and holds while the digits read zero. A non-zero digit ends it, and so does a decimal point marked on the current digit. Once released, suppression stays released until the next pass. The least significant digit is never blanked, so a zero reading still shows one `0`. An overflow indication unblanks any digit on which it is present. A scan reset input parks the scanner at the most significant position with no strobe and the display blanked. Scanning restarts cleanly on the first scan-clock fall after the reset is released.

The decimal point and overflow inputs are sampled at the digit boundary, together with the digit value. All outputs are registered and change only at digit boundaries, so every strobe lies inside stable data.

Top module: `scan_display`

## Requirements
- R1: Each falling edge of `scan_clk_i` while the scanner runs moves the selected digit one place toward the least significant digit. The selected digit index k runs from 7 (most significant) down to 0 (least significant), and a fall while digit 0 is selected returns to digit 7.
- R2: While `scan_rst_i` is high, `strobe_o` is all zero, `blank_o` is 1 and `bcd_o` is 0. After release the scanner stays idle, in that same output state, until the next `scan_clk_i` fall, which selects digit 7.
- R3: While digit k is selected, exactly one strobe is high, namely `strobe_o[k]`, and `bcd_o` equals `digits_i[4k+3:4k]` as sampled at the start of that digit time.
- R4: A pass begins with suppression armed. A digit whose value is zero, entered while suppression is still armed and with `dp_i` low, is shown with `blank_o` high, unless R7 or R8 applies.
- R5: The first non-zero digit of a pass is shown unblanked. All later digits of the same pass, zeros included, are shown unblanked.
- R6: `dp_i` high when a digit starts releases suppression for that digit and for all later digits of the pass, even when the digit is zero.
- R7: `blank_o` is 0 whenever digit 0 is selected.
- R8: `ovf_i` high when a digit starts makes that digit unblanked. It does not release suppression for later digits.
- R9: Suppression is re-armed every time digit 7 is entered, so leading zeros of a new pass are blanked again after a pass that had shown digits.
- R10: `bcd_o`, `strobe_o` and `blank_o` change only at a digit boundary or on scan reset. A change of `digits_i` during a digit time does not change `bcd_o` before the next digit.
- R11: After `rst`, `strobe_o` is all zero, `blank_o` is 1 and `bcd_o` is 0 until the first `scan_clk_i` fall, which selects digit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_clk_i | input | 1 | Scan clock; the scanner advances on its falling edge |
| scan_rst_i | input | 1 | Scan reset; high parks the scanner at the most significant digit, blanked |
| dp_i | input | 1 | Decimal point marker for the digit being entered |
| ovf_i | input | 1 | Overflow indication; unblanks the digit being entered |
| digits_i | input | 32 | Eight BCD decades, digit k in bits 4k+3:4k, digit 0 least significant |
| bcd_o | output | 4 | Value of the selected digit |
| strobe_o | output | 8 | One-hot digit strobe, bit k for digit k |
| blank_o | output | 1 | High when the display is to be dark |

## Verification
The bench walks full passes of all-zero readings, readings with leading zeros that end in a non-zero digit, and readings with a decimal point on a zero digit. It also covers overflow on single digits, back-to-back passes, scan resets in the middle of a pass and random readings. A design that did not re-arm at the most significant digit would leave the second pass's leading zeros lit. A design that let overflow clear suppression would light zeros after the overflowed digit. A design that forgot the least significant digit would show a zero reading as fully dark. Changing a decade during a digit time exposes a design whose bus follows the input rather than holding it until the next boundary. Checking right after a scan reset release, before any scan-clock fall, exposes a design that restarts out of phase.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int BCD_W       = 4;
    localparam int DIGITS_DEF  = 8;
    localparam int SYNC_DEF    = 2;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic [BCD_W-1:0] bcd;
        logic             blank;
    } disp_t;

    function automatic logic bcd_is_zero(input logic [BCD_W-1:0] d);
        return (d == '0);
    endfunction

endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync
    import scan_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic scan_clk_i,
    input  logic scan_rst_i,
    output logic fall_o,
    output logic hold_o
);

    localparam int CLK_TAPS = STAGES + 1;

    logic [CLK_TAPS-1:0] clk_sh;
    logic [STAGES-1:0]   hold_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sh  <= '1;
            hold_sh <= '0;
        end else begin
            clk_sh  <= {clk_sh[CLK_TAPS-2:0], scan_clk_i};
            hold_sh <= {hold_sh[STAGES-2:0], scan_rst_i};
        end
    end

    assign fall_o = clk_sh[CLK_TAPS-1] & ~clk_sh[CLK_TAPS-2];
    assign hold_o = hold_sh[STAGES-1];

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
#(
    parameter int N_DIGITS = DIGITS_DEF,
    parameter int IDX_W    = $clog2(N_DIGITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    input  logic             hold_i,
    output logic             upd_o,
    output logic             nxt_run_o,
    output logic [IDX_W-1:0] nxt_pos_o
);

    localparam logic [IDX_W-1:0] TOP_POS = IDX_W'(N_DIGITS - 1);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] pos_q, pos_d;

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (hold_i) begin
            state_d = SCAN_IDLE;
            pos_d   = TOP_POS;
        end else if (fall_i) begin
            state_d = SCAN_RUN;
            if (state_q == SCAN_IDLE || pos_q == '0) begin
                pos_d = TOP_POS;
            end else begin
                pos_d = pos_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            pos_q   <= TOP_POS;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    assign upd_o     = hold_i | fall_i;
    assign nxt_run_o = (state_d == SCAN_RUN);
    assign nxt_pos_o = pos_d;

endmodule

// File: rtl/blank_ctl.sv
module blank_ctl
    import scan_pkg::*;
#(
    parameter int N_DIGITS = DIGITS_DEF,
    parameter int IDX_W    = $clog2(N_DIGITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_i,
    input  logic             nxt_run_i,
    input  logic [IDX_W-1:0] nxt_pos_i,
    input  logic [BCD_W-1:0] nxt_digit_i,
    input  logic             dp_i,
    input  logic             ovf_i,
    output logic             blank_nxt_o
);

    localparam logic [IDX_W-1:0] TOP_POS = IDX_W'(N_DIGITS - 1);

    logic sup_q;
    logic armed;
    logic sup_d;

    always_comb begin
        armed       = (nxt_pos_i == TOP_POS) ? 1'b1 : sup_q;
        sup_d       = armed && bcd_is_zero(nxt_digit_i) && !dp_i;
        blank_nxt_o = !nxt_run_i || (sup_d && (nxt_pos_i != '0) && !ovf_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sup_q <= 1'b1;
        end else if (upd_i) begin
            sup_q <= sup_d;
        end
    end

endmodule

// File: rtl/disp_out.sv
module disp_out
    import scan_pkg::*;
#(
    parameter int N_DIGITS = DIGITS_DEF,
    parameter int IDX_W    = $clog2(N_DIGITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd_i,
    input  logic                nxt_run_i,
    input  logic [IDX_W-1:0]    nxt_pos_i,
    input  logic [BCD_W-1:0]    nxt_digit_i,
    input  logic                blank_nxt_i,
    output logic [BCD_W-1:0]    bcd_o,
    output logic [N_DIGITS-1:0] strobe_o,
    output logic                blank_o
);

    disp_t               disp_q, disp_d;
    logic [N_DIGITS-1:0] strb_q, strb_d;

    for (genvar k = 0; k < N_DIGITS; k++) begin : g_strb
        assign strb_d[k] = nxt_run_i && (nxt_pos_i == IDX_W'(k));
    end

    always_comb begin
        disp_d.bcd   = nxt_run_i ? nxt_digit_i : '0;
        disp_d.blank = blank_nxt_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_q.bcd   <= '0;
            disp_q.blank <= 1'b1;
            strb_q       <= '0;
        end else if (upd_i) begin
            disp_q <= disp_d;
            strb_q <= strb_d;
        end
    end

    assign bcd_o    = disp_q.bcd;
    assign blank_o  = disp_q.blank;
    assign strobe_o = strb_q;

endmodule

// File: rtl/scan_display.sv
module scan_display
    import scan_pkg::*;
#(
    parameter int N_DIGITS    = DIGITS_DEF,
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scan_clk_i,
    input  logic                      scan_rst_i,
    input  logic                      dp_i,
    input  logic                      ovf_i,
    input  logic [N_DIGITS*BCD_W-1:0] digits_i,
    output logic [BCD_W-1:0]          bcd_o,
    output logic [N_DIGITS-1:0]       strobe_o,
    output logic                      blank_o
);

    localparam int IDX_W = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1;

    logic             fall_s;
    logic             hold_s;
    logic             upd;
    logic             nxt_run;
    logic [IDX_W-1:0] nxt_pos;
    logic [BCD_W-1:0] nxt_digit;
    logic             blank_nxt;
    logic [BCD_W-1:0] dig_arr [N_DIGITS];

    for (genvar k = 0; k < N_DIGITS; k++) begin : g_unpack
        assign dig_arr[k] = digits_i[k*BCD_W +: BCD_W];
    end

    assign nxt_digit = dig_arr[nxt_pos];

    scan_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst        (rst),
        .scan_clk_i (scan_clk_i),
        .scan_rst_i (scan_rst_i),
        .fall_o     (fall_s),
        .hold_o     (hold_s)
    );

    scan_seq #(
        .N_DIGITS (N_DIGITS),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fall_i    (fall_s),
        .hold_i    (hold_s),
        .upd_o     (upd),
        .nxt_run_o (nxt_run),
        .nxt_pos_o (nxt_pos)
    );

    blank_ctl #(
        .N_DIGITS (N_DIGITS),
        .IDX_W    (IDX_W)
    ) u_blank (
        .clk         (clk),
        .rst         (rst),
        .upd_i       (upd),
        .nxt_run_i   (nxt_run),
        .nxt_pos_i   (nxt_pos),
        .nxt_digit_i (nxt_digit),
        .dp_i        (dp_i),
        .ovf_i       (ovf_i),
        .blank_nxt_o (blank_nxt)
    );

    disp_out #(
        .N_DIGITS (N_DIGITS),
        .IDX_W    (IDX_W)
    ) u_out (
        .clk         (clk),
        .rst         (rst),
        .upd_i       (upd),
        .nxt_run_i   (nxt_run),
        .nxt_pos_i   (nxt_pos),
        .nxt_digit_i (nxt_digit),
        .blank_nxt_i (blank_nxt),
        .bcd_o       (bcd_o),
        .strobe_o    (strobe_o),
        .blank_o     (blank_o)
    );

endmodule

// File: rtl/scan_display_chk.sv
module scan_display_chk #(
    parameter int N_DIGITS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                hold,
    input logic                fall,
    input logic [3:0]          bcd_o,
    input logic [N_DIGITS-1:0] strobe_o,
    input logic                blank_o
);

    // R3: never more than one strobe
    p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

    // R2: scan reset parks the outputs dark and strobe-free
    p_hold_dark_r2: assert property (@(posedge clk) disable iff (rst)
        hold |=> (strobe_o == '0 && blank_o && bcd_o == '0));

    // R7: least significant digit always lit
    p_lsd_lit_r7: assert property (@(posedge clk) disable iff (rst)
        strobe_o[0] |-> !blank_o);

    // R5: a non-zero leading digit is lit
    p_msd_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe_o[N_DIGITS-1] && bcd_o != '0) |-> !blank_o);

    // R10: outputs hold between boundaries
    p_steady_r10: assert property (@(posedge clk) disable iff (rst)
        !(hold || fall) |=> ($stable(bcd_o) && $stable(strobe_o) && $stable(blank_o)));

    // R1: wrap from the last digit to the first
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (fall && !hold && strobe_o[0]) |=> strobe_o[N_DIGITS-1]);

    // R1: one step toward the least significant digit
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (fall && !hold && strobe_o[N_DIGITS-1:1] != '0) |=> (strobe_o == ($past(strobe_o) >> 1)));

    // R11: idle scanner keeps the display dark
    p_idle_dark_r11: assert property (@(posedge clk) disable iff (rst)
        (strobe_o == '0) |-> blank_o);

endmodule

bind scan_display scan_display_chk #(
    .N_DIGITS (N_DIGITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold_s),
    .fall     (fall_s),
    .bcd_o    (bcd_o),
    .strobe_o (strobe_o),
    .blank_o  (blank_o)
);

// File: tb/test_scan_display.sv
module test_scan_display;

    localparam int ND   = 8;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scan_clk_i = 1'b1;
    logic          scan_rst_i = 1'b0;
    logic          dp_i = 1'b0;
    logic          ovf_i = 1'b0;
    logic [ND*4-1:0] digits_i;
    logic [3:0]    bcd_o;
    logic [ND-1:0] strobe_o;
    logic          blank_o;

    logic [3:0] dv [ND];
    int checks = 0;
    int fails  = 0;

    // model state
    bit e_run = 0;
    int e_pos = ND - 1;
    bit e_sup = 1;

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < ND; k++) digits_i[k*4 +: 4] = dv[k];
    end

    scan_display i_scan_display (
        .clk        (clk),
        .rst        (rst),
        .scan_clk_i (scan_clk_i),
        .scan_rst_i (scan_rst_i),
        .dp_i       (dp_i),
        .ovf_i      (ovf_i),
        .digits_i   (digits_i),
        .bcd_o      (bcd_o),
        .strobe_o   (strobe_o),
        .blank_o    (blank_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_blank(input int pos, input bit dp, input bit ovf, inout bit sup);
        bit armed;
        armed = (pos == ND - 1) ? 1'b1 : sup;
        sup   = armed && (dv[pos] == 4'd0) && !dp;
        return sup && (pos != 0) && !ovf;
    endfunction

    task automatic step(input bit dp, input bit ovf, input string btag);
        bit eb;
        @(negedge clk);
        dp_i = dp;
        ovf_i = ovf;
        scan_clk_i = 1'b0;
        if (!e_run) begin
            e_run = 1;
            e_pos = ND - 1;
        end else begin
            e_pos = (e_pos == 0) ? ND - 1 : e_pos - 1;
        end
        eb = model_blank(e_pos, dp, ovf, e_sup);
        repeat (HALF) @(negedge clk);
        chk("R1 strobe", 32'(strobe_o), 32'(1 << e_pos));
        chk("R3 bcd", 32'(bcd_o), 32'(dv[e_pos]));
        chk(btag, 32'(blank_o), 32'(eb));
        scan_clk_i = 1'b1;
        repeat (HALF) @(negedge clk);
        dp_i = 1'b0;
        ovf_i = 1'b0;
    endtask

    task automatic run_pass(input int dp_pos, input int ovf_pos, input string btag);
        for (int p = ND - 1; p >= 0; p--) begin
            step(p == dp_pos, p == ovf_pos, (p == 0) ? "R7 blank" : btag);
        end
    endtask

    task automatic set_val(input logic [31:0] v);
        for (int k = 0; k < ND; k++) dv[k] = v[k*4 +: 4];
    endtask

    initial begin
        int seed_init;
        logic [3:0] held;
        seed_init = $urandom(32'd7031);
        set_val(32'h0000_0000);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R11: reset state, idle before first fall
        chk("R11 strobe", 32'(strobe_o), 32'd0);
        chk("R11 blank", 32'(blank_o), 32'd1);
        chk("R11 bcd", 32'(bcd_o), 32'd0);

        // R4/R7: all-zero reading
        run_pass(-1, -1, "R4 blank");

        // R5: leading zeros then non-zero, later zeros lit
        set_val(32'h0001_2300);
        run_pass(-1, -1, "R5 blank");

        // R9: zeros re-armed after a lit pass
        set_val(32'h0000_0450);
        run_pass(-1, -1, "R9 blank");

        // R6: decimal point on a zero digit
        set_val(32'h0000_0000);
        run_pass(4, -1, "R6 blank");

        // R8: overflow lights one digit only
        set_val(32'h0000_0007);
        run_pass(-1, 5, "R8 blank");

        // R10: decade change mid-digit held off
        set_val(32'h9000_0001);
        step(1'b0, 1'b0, "R10 blank");
        step(1'b0, 1'b0, "R10 blank");
        held = bcd_o;
        dv[e_pos] = 4'd6;
        repeat (4) @(negedge clk);
        chk("R10 bcd held", 32'(bcd_o), 32'(held));
        for (int p = 0; p < ND - 2; p++) step(1'b0, 1'b0, "R10 blank");

        // R2: scan reset mid pass
        set_val(32'h0000_0300);
        step(1'b0, 1'b0, "R4 blank");
        step(1'b0, 1'b0, "R4 blank");
        step(1'b0, 1'b0, "R4 blank");
        @(negedge clk);
        scan_rst_i = 1'b1;
        repeat (8) @(negedge clk);
        chk("R2 strobe", 32'(strobe_o), 32'd0);
        chk("R2 blank", 32'(blank_o), 32'd1);
        chk("R2 bcd", 32'(bcd_o), 32'd0);
        scan_rst_i = 1'b0;
        e_run = 0;
        repeat (8) @(negedge clk);
        chk("R2 idle strobe", 32'(strobe_o), 32'd0);
        chk("R2 idle blank", 32'(blank_o), 32'd1);
        run_pass(-1, -1, "R2 blank");

        // random passes
        for (int n = 0; n < 30; n++) begin
            int z;
            int dpp;
            int ovp;
            z = $urandom_range(0, ND);
            for (int k = 0; k < ND; k++) begin
                if (k >= ND - z) dv[k] = 4'd0;
                else if (k == ND - z - 1) dv[k] = 4'($urandom_range(1, 9));
                else dv[k] = 4'($urandom_range(0, 9));
            end
            dpp = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, ND - 1)) : -1;
            ovp = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, ND - 1)) : -1;
            run_pass(dpp, ovp, "R5 blank rnd");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule